// File: doc/BRIEF.md
# Page Write Gather-and-Commit Buffer

This block sits behind a two-wire bus target and collects the data bytes of one write transaction into a one-page staging buffer. The bus controller first hands it a starting word address. It then passes each received data byte. Every byte lands at the current in-page offset, and that offset then advances. Only the offset bits advance, so a long burst wraps around inside the same page and overwrites bytes that came earlier. A valid flag for each slot records which offsets have been filled.

Nothing reaches the memory array until the controller signals a proper stop. At that point, if the write-protect input is low and at least one byte is held, the block raises busy for a fixed number of clock cycles. During the first page-length of that interval it walks the offsets in ascending order and issues one write for each filled slot. While busy is high, every input from the bus side is ignored. A transaction that ends in a repeated start, that carries no data, or that meets write-protect at its stop is dropped without any array access.

Top module: `page_commit_buf`

## Requirements
- R1: After reset, busy_o and mem_we are low.
- R2: Bytes received after an address load go to consecutive in-page offsets, starting at the loaded offset. At commit, each is written to the address whose upper 9 bits are the loaded page and whose lower 6 bits are its offset.
- R3: The offset is the low 6 address bits. After offset 63 it wraps to 0, and the 9 page bits never change.
- R4: When more than 64 bytes arrive, each offset holds the last byte sent to it, and each address is written once.
- R5: On a partial page, only the offsets that received bytes are written.
- R6: No array write occurs before the stop. Writes start in the cycle after the stop is sampled and go out in ascending offset order, one offset per cycle.
- R7: An accepted commit holds busy_o high for exactly BUSY_CYCLES cycles, starting in the cycle after the stop.
- R8: While busy_o is high, addr_ld, byte_vld, stop_stb and abort_stb have no effect: busy is not extended, and no byte is stored.
- R9: If wp_in is high when the stop is sampled, no write occurs, busy stays low, and the staged bytes are discarded.
- R10: An abort (the transaction ending in a repeated start) discards the staged bytes, so a later stop commits nothing.
- R11: A stop with no staged byte leaves busy_o low and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_ld | input | 1 | Load the starting word address and clear the staged bytes |
| addr_in | input | 15 | Starting word address: page in bits 14:6, offset in bits 5:0 |
| byte_vld | input | 1 | A data byte is present on byte_in |
| byte_in | input | 8 | Received data byte |
| stop_stb | input | 1 | A valid stop ended the write transaction |
| abort_stb | input | 1 | The transaction ended in a repeated start |
| wp_in | input | 1 | Write protect, sampled at the stop |
| busy_o | output | 1 | Self-timed commit in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 15 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
A stuck or mis-stepped offset counter shows up as writes to the wrong addresses. These appear in the same commit scan, within 64 cycles of the stop. A lost or stale valid flag shows up as a missing, extra or repeated write. In the protect, abort and empty cases it shows up as busy rising when it should stay low. An error in the busy counter changes the length of the busy pulse, so the bench counts every busy cycle of each commit and checks that the count is exact.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SCAN   = 2'd1,
    PH_SETTLE = 2'd2
  } commit_ph_e;
endpackage

// File: rtl/pcb_addr_ctr.sv
module pcb_addr_ctr #(
  parameter int ADDR_W = 15,
  parameter int OFF_W  = 6,
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              adv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [PAGE_W-1:0] page_o,
  output logic [OFF_W-1:0]  off_o
);
  logic [PAGE_W-1:0] page_q, page_d;
  logic [OFF_W-1:0]  off_q, off_d;

  always_comb begin
    page_d = page_q;
    off_d  = off_q;
    if (ld) begin
      page_d = addr_in[ADDR_W-1:OFF_W];
      off_d  = addr_in[OFF_W-1:0];
    end else if (adv) begin
      off_d = off_q + OFF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      off_q  <= '0;
    end else if (ld || adv) begin
      page_q <= page_d;
      off_q  <= off_d;
    end
  end

  assign page_o = page_q;
  assign off_o  = off_q;

  // R3: page bits hold while bytes stream in
  a_r3_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld) |=> $stable(page_q));
  // R3: offset wraps from the top slot to slot zero
  a_r3_off_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld && (&off_q)) |=> (off_q == '0));
endmodule

// File: rtl/pcb_page_store.sv
module pcb_page_store #(
  parameter int OFF_W  = 6,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic              lock,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic [DEPTH-1:0]  vld_o
);
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = wr && (wr_off == OFF_W'(g));

    always_ff @(posedge clk) begin
      if (hit) slot_q[g] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                vld_q[g] <= 1'b0;
      else if (clr)              vld_q[g] <= 1'b0;
      else if (hit)              vld_q[g] <= 1'b1;
    end
  end

  assign rd_data = slot_q[rd_off];
  assign vld_o   = vld_q;

  // R8: staged contents are frozen during a commit
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !clr) |=> $stable(vld_q));
endmodule

// File: rtl/pcb_commit_seq.sv
module pcb_commit_seq
  import pcb_pkg::*;
#(
  parameter int PAGE_BYTES  = 64,
  parameter int BUSY_CYCLES = 250000,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             busy_o,
  output logic             scan_o,
  output logic [OFF_W-1:0] idx_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(PAGE_BYTES - 1);
  localparam logic [CNT_W-1:0] BUSY_END = CNT_W'(BUSY_CYCLES - 1);

  commit_ph_e       ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (go) begin
          ph_d  = PH_SCAN;
          cnt_d = '0;
        end
      end
      PH_SCAN: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == BUSY_END)      ph_d = PH_IDLE;
        else if (cnt_q == SCAN_END) ph_d = PH_SETTLE;
      end
      PH_SETTLE: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == BUSY_END) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = (ph_q != PH_IDLE);
  assign scan_o = (ph_q == PH_SCAN);
  assign idx_o  = cnt_q[OFF_W-1:0];
  assign done_o = busy_o && (cnt_q == BUSY_END);

  // R7: accepted stop raises busy next cycle
  a_r7_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy_o);
  // R7: busy holds until the terminal count
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
  // R7: busy drops after terminal count
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  // R6: scan visits offsets one per cycle in rising order
  a_r6_scan_step: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_o && !done_o && (idx_o != '1)) |=> (scan_o && idx_o == $past(idx_o) + OFF_W'(1)));
endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf #(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 64,
  parameter int BUSY_CYCLES = 250000,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              stop_stb,
  input  logic              abort_stb,
  input  logic              wp_in,
  output logic              busy_o,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic              busy, scan, done, accept;
  logic              ld, wr, go, drop, clr, any_vld;
  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  off, idx;
  logic [PAGE_BYTES-1:0] vld;
  logic [DATA_W-1:0] rd_data;

  assign accept  = !busy;
  assign ld      = accept && addr_ld;
  assign wr      = accept && byte_vld && !addr_ld;
  assign any_vld = |vld;
  assign go      = accept && stop_stb && !wp_in && any_vld;
  assign drop    = accept && (abort_stb || (stop_stb && (wp_in || !any_vld)));
  assign clr     = ld || drop || done;

  pcb_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .ld(ld), .adv(wr), .addr_in(addr_in),
    .page_o(page), .off_o(off)
  );

  pcb_page_store #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr(wr), .wr_off(off), .wr_data(byte_in),
    .clr(clr), .lock(busy), .rd_off(idx), .rd_data(rd_data), .vld_o(vld)
  );

  pcb_commit_seq #(.PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .busy_o(busy), .scan_o(scan),
    .idx_o(idx), .done_o(done)
  );

  assign busy_o    = busy;
  assign mem_we    = scan && vld[idx];
  assign mem_addr  = {page, idx};
  assign mem_wdata = rd_data;

  // R6: array writes happen only inside a commit
  a_r6_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy_o);
  // R9: protected stop never starts a commit
  a_r9_wp_block: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_stb && wp_in && !busy_o) |=> !busy_o);
  // R11: empty stop never starts a commit
  a_r11_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_stb && !busy_o && vld == '0) |=> !busy_o);
  // R8: no new commit is launched from inside a commit
  a_r8_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !go);
endmodule

// File: tb/sim_page_commit_buf.sv
module sim_page_commit_buf;
  localparam int BUSY = 80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_ld = 1'b0;
  logic [14:0] addr_in = '0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_in = '0;
  logic        stop_stb = 1'b0;
  logic        abort_stb = 1'b0;
  logic        wp_in = 1'b0;
  logic        busy_o, mem_we;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata;

  int n_chk = 0;
  int n_bad = 0;

  logic [14:0] la [128];
  logic [7:0]  lw [128];
  int          lcnt = 0;
  int          bcnt = 0;
  logic [14:0] ea [64];
  logic [7:0]  ed [64];
  int          ecnt = 0;

  always #10 clk = ~clk;

  page_commit_buf #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
    .byte_vld(byte_vld), .byte_in(byte_in), .stop_stb(stop_stb),
    .abort_stb(abort_stb), .wp_in(wp_in), .busy_o(busy_o), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o) bcnt++;
      if (mem_we) begin
        if (lcnt < 128) begin
          la[lcnt] = mem_addr;
          lw[lcnt] = mem_wdata;
        end
        lcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    lcnt = 0; bcnt = 0; ecnt = 0;
  endtask

  task automatic load(input logic [14:0] a);
    @(negedge clk); addr_ld = 1'b1; addr_in = a;
    @(negedge clk); addr_ld = 1'b0;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); byte_vld = 1'b1; byte_in = b;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic stop(input logic wp);
    @(negedge clk); stop_stb = 1'b1; wp_in = wp;
    @(negedge clk); stop_stb = 1'b0; wp_in = 1'b0;
  endtask

  task automatic abort();
    @(negedge clk); abort_stb = 1'b1;
    @(negedge clk); abort_stb = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy_o; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_w(input logic [14:0] a, input logic [7:0] d);
    ea[ecnt] = a; ed[ecnt] = d; ecnt++;
  endtask

  task automatic cmp_log(input string req);
    chk(lcnt == ecnt, req, lcnt, ecnt);
    for (int i = 0; i < ecnt && i < lcnt; i++) begin
      chk(la[i] == ea[i], req, la[i], ea[i]);
      chk(lw[i] == ed[i], req, lw[i], ed[i]);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
    chk(mem_we == 1'b0, "R1 we", mem_we, 0);
  endtask

  task automatic t_partial();
    clear_logs();
    load(15'h1234);
    put(8'hA1); put(8'hB2); put(8'hC3);
    repeat (5) @(negedge clk);
    chk(lcnt == 0, "R6 no write before stop", lcnt, 0);
    stop(1'b0);
    chk(busy_o == 1'b1, "R7 busy after stop", busy_o, 1);
    wait_idle();
    chk(bcnt == BUSY, "R7 busy length", bcnt, BUSY);
    expect_w(15'h1234, 8'hA1);
    expect_w(15'h1235, 8'hB2);
    expect_w(15'h1236, 8'hC3);
    cmp_log("R2 R5 R6 partial");
  endtask

  task automatic t_wrap();
    clear_logs();
    load({9'd5, 6'd62});
    put(8'h11); put(8'h22); put(8'h33); put(8'h44);
    stop(1'b0);
    wait_idle();
    expect_w({9'd5, 6'd0}, 8'h33);
    expect_w({9'd5, 6'd1}, 8'h44);
    expect_w({9'd5, 6'd62}, 8'h11);
    expect_w({9'd5, 6'd63}, 8'h22);
    cmp_log("R3 wrap in page");
  endtask

  task automatic t_overflow();
    clear_logs();
    load({9'd3, 6'd10});
    for (int i = 0; i < 66; i++) put(8'(i));
    stop(1'b0);
    wait_idle();
    for (int k = 0; k < 64; k++) begin
      int b;
      b = (k - 10 + 64) % 64;
      if (b + 64 < 66) b = b + 64;
      expect_w({9'd3, 6'(k)}, 8'(b));
    end
    cmp_log("R4 overflow overwrite");
    chk(bcnt == BUSY, "R7 busy length full page", bcnt, BUSY);
  endtask

  task automatic t_ignore_busy();
    clear_logs();
    load(15'h0200);
    put(8'h5A);
    stop(1'b0);
    load(15'h0300);
    put(8'h66);
    stop(1'b0);
    abort();
    wait_idle();
    chk(bcnt == BUSY, "R8 busy not extended", bcnt, BUSY);
    expect_w(15'h0200, 8'h5A);
    cmp_log("R8 inputs ignored while busy");
    stop(1'b0);
    repeat (5) @(negedge clk);
    chk(bcnt == BUSY, "R8 byte during busy not stored", bcnt, BUSY);
    chk(lcnt == 1, "R8 no extra write", lcnt, 1);
  endtask

  task automatic t_wp();
    clear_logs();
    load(15'h4000);
    put(8'h01); put(8'h02);
    stop(1'b1);
    repeat (100) @(negedge clk);
    chk(bcnt == 0, "R9 no busy under protect", bcnt, 0);
    chk(lcnt == 0, "R9 no write under protect", lcnt, 0);
    stop(1'b0);
    repeat (10) @(negedge clk);
    chk(bcnt == 0, "R9 protected bytes discarded", bcnt, 0);
  endtask

  task automatic t_abort();
    clear_logs();
    load(15'h0777);
    put(8'hEE); put(8'hFF);
    abort();
    stop(1'b0);
    repeat (10) @(negedge clk);
    chk(bcnt == 0, "R10 abort discards", bcnt, 0);
    chk(lcnt == 0, "R10 no write after abort", lcnt, 0);
  endtask

  task automatic t_empty();
    clear_logs();
    load(15'h0100);
    stop(1'b0);
    repeat (10) @(negedge clk);
    chk(bcnt == 0, "R11 empty stop no busy", bcnt, 0);
    chk(lcnt == 0, "R11 empty stop no write", lcnt, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_partial();
    t_wrap();
    t_overflow();
    t_ignore_busy();
    t_wp();
    t_abort();
    t_empty();
    finish_run();
  end
endmodule